// File: doc/BRIEF.md
# Interrupt Request Controller

The block gathers a build-time number of interrupt request lines, records each request in a status register and raises one interrupt line towards a processor. A fixed kind mask decides, input by input, whether a line is captured on its rising transition or sampled as a level. Software masks inputs through an enable register. It learns which input to serve from a vector register that names the lowest-numbered enabled request. It retires requests by writing a bit mask to an acknowledge register.

The bus side is a single 32-bit word port with one access per cycle. A write happens on the clock edge when `we_i` is high. Reads are combinational from `addr_i`. Eight word registers occupy byte offsets 0x00 to 0x1C. A two-bit master control register must have both bits set before the output can assert.

Top module: `irq_ctrl`

## Requirements
- R1: Byte offsets select status 0x00, pending 0x04, enable 0x08, acknowledge 0x0C, enable-set 0x10, enable-clear 0x14, vector 0x18 and master control 0x1C. The acknowledge, enable-set and enable-clear words read as zero. Writes to status, pending and vector have no effect.
- R2: Writing a mask to acknowledge clears the status bits where the mask holds ones on the next edge. Writing 0xFFFFFFFF clears every status bit.
- R3: Writing a mask to enable-set sets the matching enable bits, and writing to enable-clear clears them. All other enable bits keep their value.
- R4: Writing to the enable word replaces the whole enable register, so writing zero disables every input.
- R5: An input whose bit in parameter KIND_MASK is 1 sets its status bit only on a rising transition relative to the value sampled on the previous edge. A held-high line does not set it again after an acknowledge.
- R6: An input whose kind bit is 0 sets its status bit on every edge at which it is high, so after an acknowledge the bit sets again while the line stays high.
- R7: A capture and an acknowledge of the same bit on the same edge leave the status bit set.
- R8: The pending word reads as status AND enable.
- R9: irq_o is high exactly when some pending bit is set and master control bit 0 (master enable) and bit 1 (hardware output enable) are both 1.
- R10: The vector word reads the index of the lowest-numbered pending bit, zero-extended, and 0xFFFFFFFF when no bit is pending.
- R11: After reset every register is zero and irq_o is low. Status, pending and enable bits at positions NUM_IN and above always read zero. KIND_MASK bits above NUM_IN have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | NUM_IN | Interrupt request lines, synchronous to clk_i |
| addr_i | input | 5 | Byte address; bits 1:0 are ignored |
| we_i | input | 1 | Write strobe for this cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Interrupt to the processor |

## Verification
The assertions assume that the request lines are already synchronous to the clock and that the port carries at most one write per cycle. The acknowledge and enable masks may overlap arbitrary capture activity. The bench changes request lines and bus signals only just after the falling edge, with word-aligned addresses. Random request toggles are mixed with random writes to all eight words, so acknowledges regularly coincide with captures and with level lines held high.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 5;

  // word index = addr[4:2]
  typedef enum logic [2:0] {
    SEL_STAT = 3'd0,
    SEL_PEND = 3'd1,
    SEL_EN   = 3'd2,
    SEL_ACK  = 3'd3,
    SEL_SET  = 3'd4,
    SEL_CLR  = 3'd5,
    SEL_VEC  = 3'd6,
    SEL_MCTL = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/irq_capture.sv
`timescale 1ns/1ps
module irq_capture #(
  parameter int unsigned NUM_IN    = 16,
  parameter logic [31:0] KIND_MASK = 32'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] src_i,
  input  logic [NUM_IN-1:0] ack_i,
  output logic [NUM_IN-1:0] status_o
);
  logic [NUM_IN-1:0] src_q, set_s, status_q;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_cap
    if (KIND_MASK[i]) begin : g_edge
      assign set_s[i] = src_i[i] & ~src_q[i];
    end else begin : g_level
      assign set_s[i] = src_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= '0;
      status_q <= '0;
    end else begin
      src_q    <= src_i;
      status_q <= (status_q & ~ack_i) | set_s;   // capture beats acknowledge
    end
  end

  assign status_o = status_q;

  a_r7_capture_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_s) |=> ((status_q & $past(set_s)) == $past(set_s)));

  a_r2_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ack_i & ~set_s)) |=> ((status_q & $past(ack_i & ~set_s)) == '0));

  a_r5_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ack_i | set_s) == '0) |=> $stable(status_q));
endmodule

// File: rtl/irq_enable.sv
`timescale 1ns/1ps
module irq_enable
  import intc_pkg::*;
#(
  parameter int unsigned NUM_IN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  reg_sel_e          sel_i,
  input  logic [NUM_IN-1:0] mask_i,
  output logic [NUM_IN-1:0] en_o
);
  logic [NUM_IN-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_EN:  en_q <= mask_i;
        SEL_SET: en_q <= en_q | mask_i;
        SEL_CLR: en_q <= en_q & ~mask_i;
        default: en_q <= en_q;
      endcase
    end
  end

  assign en_o = en_q;

  a_r3_set_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_SET) |=>
      ((en_q & $past(mask_i)) == $past(mask_i)) &&
      ((en_q & ~$past(mask_i)) == ($past(en_q) & ~$past(mask_i))));

  a_r3_clr_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_CLR) |=>
      ((en_q & $past(mask_i)) == '0) &&
      ((en_q & ~$past(mask_i)) == ($past(en_q) & ~$past(mask_i))));

  a_r4_no_write_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(en_q));
endmodule

// File: rtl/irq_prio.sv
`timescale 1ns/1ps
module irq_prio #(
  parameter int unsigned NUM_IN = 16,
  localparam int unsigned IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic [NUM_IN-1:0] pend_i,
  output logic              valid_o,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign valid_o = |pend_i;

  always_comb begin
    if (valid_o) begin
      a_r10_idx_pending: assert (pend_i[idx_o]);
      a_r10_idx_lowest: assert ((pend_i & ((NUM_IN'(1) << idx_o) - NUM_IN'(1))) == '0);
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
module irq_ctrl
  import intc_pkg::*;
#(
  parameter int unsigned NUM_IN    = 16,   // 1..32
  parameter logic [31:0] KIND_MASK = 32'h0000_0F0F,
  localparam int unsigned IDX_W    = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] irq_src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  reg_sel_e          sel;
  logic [NUM_IN-1:0] ack, status, en, pend;
  logic [1:0]        mctl_q;
  logic              vec_valid;
  logic [IDX_W-1:0]  vec_idx;
  logic [DATA_W-1:0] stat_w, pend_w, en_w, vec_w;

  assign sel = reg_sel_e'(addr_i[ADDR_W-1:2]);
  assign ack = (we_i && sel == SEL_ACK) ? wdata_i[NUM_IN-1:0] : '0;

  irq_capture #(.NUM_IN(NUM_IN), .KIND_MASK(KIND_MASK)) u_cap (
    .clk_i, .rst_ni, .src_i(irq_src_i), .ack_i(ack), .status_o(status)
  );

  irq_enable #(.NUM_IN(NUM_IN)) u_en (
    .clk_i, .rst_ni, .we_i, .sel_i(sel), .mask_i(wdata_i[NUM_IN-1:0]), .en_o(en)
  );

  assign pend = status & en;

  irq_prio #(.NUM_IN(NUM_IN)) u_prio (
    .pend_i(pend), .valid_o(vec_valid), .idx_o(vec_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        mctl_q <= '0;
    else if (we_i && sel == SEL_MCTL)   mctl_q <= wdata_i[1:0];
  end

  assign irq_o = vec_valid & mctl_q[0] & mctl_q[1];

  always_comb begin
    stat_w = '0; stat_w[NUM_IN-1:0] = status;
    pend_w = '0; pend_w[NUM_IN-1:0] = pend;
    en_w   = '0; en_w[NUM_IN-1:0]   = en;
    if (vec_valid) begin
      vec_w = '0; vec_w[IDX_W-1:0] = vec_idx;
    end else begin
      vec_w = '1;
    end
    unique case (sel)
      SEL_STAT: rdata_o = stat_w;
      SEL_PEND: rdata_o = pend_w;
      SEL_EN:   rdata_o = en_w;
      SEL_VEC:  rdata_o = vec_w;
      SEL_MCTL: rdata_o = {{(DATA_W-2){1'b0}}, mctl_q};
      default:  rdata_o = '0;   // write-only words
    endcase
  end

  a_r9_gate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mctl_q != 2'b11) |-> !irq_o);

  a_r9_irq_has_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|(status & en)));

  a_r10_vec_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_VEC && (status & en) == '0) |-> (rdata_o == '1));

  a_r11_mctl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel == SEL_MCTL) |=> $stable(mctl_q));
endmodule

// File: tb/irq_ctrl_test.sv
`timescale 1ns/1ps
module irq_ctrl_test;
  localparam int unsigned N      = 16;
  localparam logic [31:0] KIND   = 32'hFFFF_0F0F;   // bits 16+ are out of range
  localparam logic [31:0] NMASK  = 32'((64'd1 << N) - 64'd1);
  localparam logic [31:0] KEFF   = KIND & NMASK;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  irq_src_i = '0;
  logic [4:0]    addr_i = '0;
  logic          we_i = 1'b0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic          irq_o;

  int unsigned n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_stat = '0, m_en = '0, m_prev = '0;
  logic [1:0]  m_mctl = '0;

  always #4 clk_i = ~clk_i;

  irq_ctrl #(.NUM_IN(N), .KIND_MASK(KIND)) uut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_vec(input logic [31:0] p);
    for (int i = 0; i < int'(N); i++) if (p[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    addr_i = {s, 2'b00};
    #0.2;
    v = rdata_o;
  endtask

  task automatic check_all();
    logic [31:0] v;
    rd(3'd0, v); chk("R2 R5 R6 R7 R11 status", v, m_stat);
    rd(3'd1, v); chk("R8 pending", v, m_stat & m_en);
    rd(3'd2, v); chk("R3 R4 enable", v, m_en);
    rd(3'd3, v); chk("R1 ack reads zero", v, 32'h0);
    rd(3'd4, v); chk("R1 set reads zero", v, 32'h0);
    rd(3'd5, v); chk("R1 clr reads zero", v, 32'h0);
    rd(3'd6, v); chk("R10 vector", v, exp_vec(m_stat & m_en));
    rd(3'd7, v); chk("R1 master control", v, {30'h0, m_mctl});
    chk("R9 irq_o", {31'h0, irq_o},
        {31'h0, (|(m_stat & m_en)) & m_mctl[0] & m_mctl[1]});
  endtask

  // drive one cycle, update model at the edge, check after the falling edge
  task automatic step(input logic [N-1:0] src, input logic we, input logic [2:0] s,
                      input logic [31:0] d);
    logic [31:0] src32, set, ack;
    irq_src_i = src; we_i = we; addr_i = {s, 2'b00}; wdata_i = d;
    src32 = 32'(src);
    set   = ((KEFF & src32 & ~m_prev) | (~KEFF & src32)) & NMASK;
    ack   = (we && s == 3'd3) ? d : 32'h0;
    m_prev = src32;
    m_stat = ((m_stat & ~ack) | set) & NMASK;
    if (we) begin
      case (s)
        3'd2: m_en = d & NMASK;
        3'd4: m_en = (m_en | d) & NMASK;
        3'd5: m_en = m_en & ~d;
        3'd7: m_mctl = d[1:0];
        default: ;
      endcase
    end
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0;
    check_all();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] src;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    check_all();                                   // R11 reset state
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all();

    step('0, 1, 3'd7, 32'h3);                      // R9 enable output
    step('0, 1, 3'd2, 32'hFFFF_FFFF);              // R4 / R11 upper bits dropped
    // R5 edge input 0: rise, hold, ack while high stays clear
    step(16'h0001, 0, 3'd0, 0);
    step(16'h0001, 0, 3'd0, 0);
    step(16'h0001, 1, 3'd3, 32'h1);
    step(16'h0001, 0, 3'd0, 0);
    // R6 level input 4: ack while high sets again
    step(16'h0011, 0, 3'd0, 0);
    step(16'h0011, 1, 3'd3, 32'h10);
    step(16'h0001, 1, 3'd3, 32'h10);
    // R7 rise on edge input 1 in the same cycle as its ack
    step(16'h0003, 1, 3'd3, 32'h2);
    // R1 writes to read-only words ignored
    step(16'h0003, 1, 3'd0, 32'h0);
    step(16'h0003, 1, 3'd6, 32'h0);
    step(16'h0003, 1, 3'd1, 32'h0);
    // R11 inputs with out-of-range kind bits: levels 12..15 behave as level
    step(16'hF003, 0, 3'd0, 0);
    step(16'hF003, 1, 3'd3, 32'hF000);
    // R2 acknowledge everything
    step('0, 1, 3'd3, 32'hFFFF_FFFF);
    // R3 aliases, R10 priority ordering
    step(16'h0A0A, 1, 3'd5, 32'h000F);
    step('0, 1, 3'd4, 32'h0002);
    step('0, 1, 3'd5, 32'h0002);
    // R9 only one control bit set
    step('0, 1, 3'd7, 32'h1);
    step('0, 1, 3'd7, 32'h2);
    step('0, 1, 3'd7, 32'h3);
    // R4 zero disables
    step('0, 1, 3'd2, 32'h0);
    step('0, 1, 3'd3, 32'hFFFF_FFFF);

    src = '0;
    for (int k = 0; k < 5000; k++) begin
      logic [31:0] d;
      logic [2:0]  s;
      logic        w;
      src = src ^ N'($urandom & $urandom & $urandom);
      w = ($urandom % 10) < 4;
      s = 3'($urandom);
      d = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
      step(src, w, s, d);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule